// File: doc/BRIEF.md
# Oscillator Start-Up Timer

This block sequences the enabling of a clock oscillator and reports when that oscillator can be treated as settled. Software writes a control word that holds an enable bit and an 8-bit delay count. The write drives the oscillator-enable output and starts a timer that runs on the slow clock. The timer waits eight slow-clock cycles for each unit of the count, then sets a stable flag.

Software can poll the stable flag through the status register. It can also take an interrupt. An interrupt mask is set through one address and cleared through another, each using write-one semantics, and a third address reads the mask back. The interrupt line is high whenever the stable flag and its mask bit are both set. The whole block runs on the slow clock, including its register port. Reads are combinational from the read address.

Top module: `oscStartTimer`

## Requirements
- R1: After reset, oscEnable, stable and irq are 0, the mask is 0, and every register reads as zero.
- R2: A write to address 0 stores bit 0 as the enable and bits 15:8 as the count. oscEnable follows the stored enable from the next clock edge. Address 0 reads back {count in bits 15:8, enable in bit 0}, with all other bits 0.
- R3: After a write to address 0 with enable 1 and count N (N ≥ 1), stable reads 0 for the first 8·N−1 clock edges that follow the write edge. It reads 1 from edge 8·N onward. For example, a write of 0x00000701 gives 56 edges.
- R4: With count 0, stable reads 1 after the first clock edge that follows the enabling write.
- R5: A write to address 0 with bit 0 clear drops oscEnable and stable at that edge and abandons the timer. A later enabling write waits the full delay again.
- R6: An enabling write to address 0 while the block is already enabled clears stable and restarts the delay from zero, using the new count.
- R7: Writing 1 in bit 0 at address 2 sets the mask bit. Writing 1 in bit 0 at address 3 clears it. A 0 in bit 0 at either address leaves the mask unchanged. Address 4 reads the mask in bit 0.
- R8: irq is high exactly when stable and the mask bit are both 1. It rises in the same cycle as stable when the mask is already set.
- R9: Address 1 reads stable in bit 0. Writes to addresses 1 and 4–7 have no effect, and addresses 5–7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; clocks the timer and the register port |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| oscEnable | output | 1 | Oscillator enable |
| stable | output | 1 | Start-up delay has expired |
| irq | output | 1 | Stable interrupt, masked |

## Verification
The bench measures the exact edge at which stable rises for count 7, count 0 and count 255. An off-by-one in the timer load or in the terminal compare moves that edge, and a zero count handled as a wrap would stall for thousands of cycles. Disabling partway through a delay and re-enabling while already enabled both target a design that keeps the old countdown or leaves stable high. Writes with bit 0 clear to the mask addresses, and writes to read-only or unused addresses, expose decoders that ignore the data bit or alias addresses.

// File: rtl/oscStartPkg.sv
package oscStartPkg;
  typedef struct packed {
    logic ctrlWr;
    logic maskSet;
    logic maskClr;
  } oscStrobe_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_MSET  = 2;
  localparam int ADDR_MCLR  = 3;
  localparam int ADDR_MASK  = 4;
  localparam int EN_BIT     = 0;
  localparam int CNT_LSB    = 8;
  localparam int STABLE_BIT = 0;
endpackage

// File: rtl/oscCtrl.sv
module oscCtrl
  import oscStartPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              enableQ,
  input  logic [CNT_W-1:0]  countQ,
  input  logic              stableQ,
  input  logic              maskQ,
  output oscStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strobe.ctrlWr  = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
    strobe.maskSet = wrEn && (wrAddr == ADDR_W'(ADDR_MSET)) && wrData[STABLE_BIT];
    strobe.maskClr = wrEn && (wrAddr == ADDR_W'(ADDR_MCLR)) && wrData[STABLE_BIT];
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADDR_CTRL): begin
        rdData[EN_BIT] = enableQ;
        rdData[CNT_LSB +: CNT_W] = countQ;
      end
      ADDR_W'(ADDR_STAT): rdData[STABLE_BIT] = stableQ;
      ADDR_W'(ADDR_MASK): rdData[STABLE_BIT] = maskQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/oscDatapath.sv
module oscDatapath
  import oscStartPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int UNIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  oscStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              enableQ,
  output logic [CNT_W-1:0]  countQ,
  output logic              stableQ,
  output logic              maskQ,
  output logic              irq
);
  localparam int TIMER_W = CNT_W + $clog2(UNIT_CYCLES) + 1;

  logic [TIMER_W-1:0] remaining;
  logic [CNT_W-1:0]   cntIn;
  logic [TIMER_W-1:0] loadVal;

  assign cntIn   = wrData[CNT_LSB +: CNT_W];
  assign loadVal = TIMER_W'(cntIn) * TIMER_W'(UNIT_CYCLES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      countQ    <= '0;
      stableQ   <= 1'b0;
      remaining <= '0;
    end else if (strobe.ctrlWr) begin
      enableQ   <= wrData[EN_BIT];
      countQ    <= cntIn;
      stableQ   <= 1'b0;
      remaining <= wrData[EN_BIT] ? loadVal : '0;
    end else if (enableQ && !stableQ) begin
      if (remaining <= TIMER_W'(1)) stableQ <= 1'b1;
      else remaining <= remaining - TIMER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= 1'b0;
    else if (strobe.maskSet) maskQ <= 1'b1;
    else if (strobe.maskClr) maskQ <= 1'b0;
  end

  assign irq = stableQ & maskQ;
endmodule

// File: rtl/oscStartTimer.sv
module oscStartTimer
  import oscStartPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int UNIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              oscEnable,
  output logic              stable,
  output logic              irq
);
  oscStrobe_t       strobe;
  logic             enableQ;
  logic             stableQ;
  logic             maskQ;
  logic [CNT_W-1:0] countQ;

  oscCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .enableQ(enableQ), .countQ(countQ), .stableQ(stableQ), .maskQ(maskQ),
    .strobe(strobe), .rdData(rdData)
  );

  oscDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .UNIT_CYCLES(UNIT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .enableQ(enableQ), .countQ(countQ), .stableQ(stableQ), .maskQ(maskQ), .irq(irq)
  );

  assign oscEnable = enableQ;
  assign stable    = stableQ;
endmodule

// File: rtl/oscStartTimerChk.sv
module oscStartTimerChk #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int UNIT_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              oscEnable,
  input logic              stable,
  input logic              irq
);
  localparam int EDGE_W = CNT_W + $clog2(UNIT_CYCLES) + 2;

  logic              ctrlWrite;
  logic              mSetWrite;
  logic              mClrWrite;
  logic [EDGE_W-1:0] chkEdges;
  logic [EDGE_W-1:0] chkTarget;

  assign ctrlWrite = wrEn && (wrAddr == ADDR_W'(0));
  assign mSetWrite = wrEn && (wrAddr == ADDR_W'(2)) && wrData[0];
  assign mClrWrite = wrEn && (wrAddr == ADDR_W'(3)) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkEdges  <= '0;
      chkTarget <= EDGE_W'(1);
    end else if (ctrlWrite) begin
      chkEdges  <= '0;
      chkTarget <= (wrData[15:8] == 8'd0) ? EDGE_W'(1)
                 : EDGE_W'(wrData[15:8]) * EDGE_W'(UNIT_CYCLES);
    end else if (oscEnable && !stable) begin
      chkEdges <= chkEdges + EDGE_W'(1);
    end
  end

  // R3 and R4: stable rises exactly at the programmed edge
  assert_rise_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stable) |-> (chkEdges == chkTarget));

  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !wrData[0]) |=> (!oscEnable && !stable));

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && wrData[0]) |=> (oscEnable && !stable));

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    mClrWrite |=> !irq);

  assert_mask_set_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mSetWrite && stable) |=> irq);
endmodule

bind oscStartTimer oscStartTimerChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .UNIT_CYCLES(UNIT_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .oscEnable(oscEnable), .stable(stable), .irq(irq)
);

// File: tb/oscStartTimer_tb.sv
module oscStartTimer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        oscEnable, stable, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string curTag = "R1";

  logic       mEn = 0, mStable = 0, mMask = 0;
  logic [7:0] mCnt = 0;
  int         mEdges = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oscStartTimer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .oscEnable(oscEnable), .stable(stable), .irq(irq)
  );

  function automatic int targetEdges(input logic [7:0] c);
    return (c == 0) ? 1 : 8 * int'(c);
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {16'b0, mCnt, 7'b0, mEn};
      3'd1: return {31'b0, mStable};
      3'd4: return {31'b0, mMask};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic updateModel(input logic we, input logic [2:0] a, input logic [31:0] d);
    if (we && a == 3'd0) begin
      mEn = d[0]; mCnt = d[15:8]; mEdges = 0; mStable = 0;
    end else if (mEn && !mStable) begin
      mEdges++;
      mStable = (mEdges >= targetEdges(mCnt));
    end
    if (we && a == 3'd2 && d[0]) mMask = 1;
    else if (we && a == 3'd3 && d[0]) mMask = 0;
  endtask

  task automatic tick(input logic we, input logic [2:0] a, input logic [31:0] d, input logic [2:0] ra);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; rdAddr = ra;
    #1;
    chk(curTag, "oscEnable (R2)", 32'(oscEnable), 32'(mEn));
    chk(curTag, "stable (R3)", 32'(stable), 32'(mStable));
    chk(curTag, "irq (R8)", 32'(irq), 32'(mStable & mMask));
    chk(curTag, "rdData (R9)", rdData, expRead(ra));
    @(posedge clk);
    #1;
    updateModel(we, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 32'd0, 3'(i % 8));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curTag = "R1";
    for (int a = 0; a < 8; a++) tick(1'b0, 3'd0, 32'd0, 3'(a));

    curTag = "R3";
    tick(1'b1, 3'd0, 32'h0000_0701, 3'd0);
    idle(60);
    curTag = "R4";
    tick(1'b1, 3'd0, 32'h0000_0001, 3'd1);
    idle(4);
    curTag = "R5";
    tick(1'b1, 3'd0, 32'h0000_0301, 3'd1);
    idle(10);
    tick(1'b1, 3'd0, 32'h0000_0300, 3'd1);
    idle(5);
    tick(1'b1, 3'd0, 32'h0000_0301, 3'd1);
    idle(30);
    curTag = "R6";
    tick(1'b1, 3'd0, 32'h0000_0201, 3'd1);
    idle(10);
    tick(1'b1, 3'd0, 32'h0000_0401, 3'd1);
    idle(40);
    curTag = "R7";
    tick(1'b1, 3'd2, 32'hFFFF_FFFE, 3'd4);
    tick(1'b1, 3'd2, 32'h0000_0001, 3'd4);
    tick(1'b1, 3'd3, 32'hFFFF_FFFE, 3'd4);
    tick(1'b1, 3'd3, 32'h0000_0001, 3'd4);
    curTag = "R8";
    tick(1'b1, 3'd2, 32'h0000_0001, 3'd4);
    tick(1'b1, 3'd0, 32'h0000_0201, 3'd1);
    idle(20);
    curTag = "R9";
    for (int a = 4; a < 8; a++) tick(1'b1, 3'(a), 32'hFFFF_FFFF, 3'(a));
    tick(1'b1, 3'd1, 32'h0000_0000, 3'd1);
    idle(8);
    curTag = "R3";
    tick(1'b1, 3'd0, 32'h0000_FF01, 3'd0);
    idle(2045);

    curTag = "R3";
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] d;
      r = int'($urandom % 100);
      d = $urandom;
      if (r < 4) begin
        d[15:8] = 8'($urandom % 6);
        d[0] = ($urandom % 5) != 0;
        tick(1'b1, 3'd0, d, 3'($urandom % 8));
      end else if (r < 8) begin
        tick(1'b1, 3'(2 + ($urandom % 2)), d, 3'($urandom % 8));
      end else if (r < 11) begin
        tick(1'b1, 3'(($urandom % 2) ? 1 : 4 + ($urandom % 4)), d, 3'($urandom % 8));
      end else begin
        tick(1'b0, 3'($urandom % 8), d, 3'($urandom % 8));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule